// File: doc/BRIEF.md
# Buffered Host Data Port with Prefetch

This block connects the data register of a host bus to a shared 16-bit packet memory. A small byte queue sits between them. In write mode, host byte and word writes enter the queue at once. A request/grant interface then moves the data to memory at an auto-incrementing memory pointer. Each memory cycle is a byte cycle or a word cycle, and the pointer's low bit and the number of queued bytes decide which.

In read mode, loading the pointer clears any old data from the queue and starts fetching memory words right away, so data is waiting when the host reads. The block keeps requesting more data whenever the queue has room for another word. The host only has to wait when it reads from an empty queue, writes to a full one, or reloads the pointer while write data is still waiting to go to memory.

The host sets the direction (read or write) each time it loads the pointer. The memory side completes each granted cycle in a single clock.

Top module: `hdp_port`

## Requirements
- R1: After reset the port is in write mode with an empty queue. `host_ptr` is 0, `mem_req` is 0 and `host_stall` is 0.
- R2: In write mode, a byte write (`host_wdata[7:0]`) or a word write (low byte first, then high byte) is taken without stall when the 4-byte queue has room. Otherwise `host_stall` is 1 and the write has no effect for as long as it stays stalled.
- R3: In write mode, `mem_req` is 1 whenever the queue holds data, with `mem_we` = 1. An ungranted request stays asserted until it is granted.
- R4: A write cycle is a word cycle (`mem_be` = 11, even address, `mem_wdata` = {second byte, first byte}) when the pointer is even and at least 2 bytes are queued. Otherwise it is a byte cycle: `mem_be` = 01 at an even address or 10 at an odd address, with the byte copied onto both lanes.
- R5: Each granted cycle advances `mem_addr` by the number of bytes moved (1 or 2).
- R6: `host_ptr` advances by the number of bytes the host writes or reads without stall.
- R7: A pointer load with `host_ptr_rd` = 1 empties the queue and sets both pointers to `host_ptr_val`. From the next cycle it requests a read (`mem_we` = 0): a word read at an even address, or a high-lane byte read (`mem_be` = 10) at an odd address.
- R8: In read mode, `mem_req` is 1 exactly when the queue holds 2 bytes or fewer, so prefetch stops at 3 or 4 bytes and resumes after the host reads.
- R9: A host word read returns {second byte, first byte}. A byte read returns the first byte in bits 7:0 with bits 15:8 zero. A read asking for more bytes than are queued stalls.
- R10: A pointer load while write-mode data is still queued stalls, changes nothing, and takes effect in the first cycle after the queue has drained.
- R11: In read mode a host write strobe, and in write mode a host read strobe, has no effect and does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ptr_load | input | 1 | Load the pointer and set the direction |
| host_ptr_rd | input | 1 | Direction for the load: 1 = read, 0 = write |
| host_ptr_val | input | ADDR_W | Pointer value to load |
| host_wr_byte | input | 1 | Host byte write strobe |
| host_wr_word | input | 1 | Host word write strobe |
| host_wdata | input | 16 | Host write data |
| host_rd_byte | input | 1 | Host byte read strobe |
| host_rd_word | input | 1 | Host word read strobe |
| host_rdata | output | 16 | Host read data, valid during the read strobe |
| host_stall | output | 1 | The current host request cannot complete this cycle |
| host_ptr | output | ADDR_W | Pointer as seen by the host |
| mem_req | output | 1 | Memory cycle request |
| mem_gnt | input | 1 | Grant; the cycle completes on this edge |
| mem_we | output | 1 | 1 = memory write cycle |
| mem_addr | output | ADDR_W | Byte address of the memory cycle |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the grant cycle |

## Verification
A wrong queue count or index shows up at the ports within one or two cycles. It appears as a wrong byte on `host_rdata`, a stall where none is due, or a request that stays up or drops at the wrong fill level. A wrong memory pointer or a wrong size decision shows on `mem_addr` and `mem_be` in the next granted cycle, and a bad lane choice corrupts the modelled memory word at once. The tests start at odd and even pointers, fill the queue to its limit, and load the pointer while write data is still queued, so that each size rule and each stall condition is reached.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
    typedef enum logic {
        MODE_WR = 1'b0,
        MODE_RD = 1'b1
    } hdp_mode_e;

    localparam int unsigned LANE_W  = 8;
    localparam int unsigned LANES   = 2;
    localparam int unsigned WORD_W  = LANE_W * LANES;
endpackage

// File: rtl/hdp_fifo.sv
module hdp_fifo
    import hdp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        push_n,
    input  logic [WORD_W-1:0] push_data,
    input  logic [1:0]        pop_n,
    output logic [CW-1:0]     count,
    output logic [WORD_W-1:0] head
);
    typedef struct packed {
        logic [DEPTH-1:0][LANE_W-1:0] slot;
        logic [IW-1:0]                rd;
        logic [IW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } fifo_t;

    fifo_t s_d, s_q;

    function automatic logic [IW-1:0] step_idx(logic [IW-1:0] idx, logic [1:0] k);
        logic [IW+1:0] sum;
        sum = (IW+2)'(idx) + (IW+2)'(k);
        if (sum >= (IW+2)'(DEPTH))
            sum = sum - (IW+2)'(DEPTH);
        return sum[IW-1:0];
    endfunction

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (2'(k) < push_n)
                    s_d.slot[step_idx(s_q.wr, 2'(k))] = push_data[k*LANE_W +: LANE_W];
            end
            s_d.wr  = step_idx(s_q.wr, push_n);
            s_d.rd  = step_idx(s_q.rd, pop_n);
            s_d.cnt = s_q.cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head[g*LANE_W +: LANE_W] = s_q.slot[step_idx(s_q.rd, 2'(g))];
    end
endmodule

// File: rtl/hdp_cyc_sel.sv
module hdp_cyc_sel
    import hdp_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  hdp_mode_e     mode,
    input  logic [CW-1:0] count,
    input  logic          ptr_lsb,
    output logic          req,
    output logic          word,
    output logic [1:0]    be
);
    localparam logic [CW-1:0] REFILL_AT = CW'(DEPTH - LANES);

    always_comb begin
        if (mode == MODE_WR) begin
            req  = (count != '0);
            word = !ptr_lsb && (count >= CW'(LANES));
        end else begin
            req  = (count <= REFILL_AT);
            word = !ptr_lsb;
        end
        if (word)
            be = 2'b11;
        else
            be = ptr_lsb ? 2'b10 : 2'b01;
    end
endmodule

// File: rtl/hdp_port.sv
module hdp_port
    import hdp_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ptr_load,
    input  logic              host_ptr_rd,
    input  logic [ADDR_W-1:0] host_ptr_val,
    input  logic              host_wr_byte,
    input  logic              host_wr_word,
    input  logic [15:0]       host_wdata,
    input  logic              host_rd_byte,
    input  logic              host_rd_word,
    output logic [15:0]       host_rdata,
    output logic              host_stall,
    output logic [ADDR_W-1:0] host_ptr,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);
    typedef struct packed {
        hdp_mode_e         mode;
        logic [ADDR_W-1:0] mem_ptr;
        logic [ADDR_W-1:0] host_ptr;
    } port_t;

    port_t s_d, s_q;

    logic [CW-1:0]     fifo_count;
    logic [WORD_W-1:0] fifo_head;
    logic [1:0]        push_n, pop_n;
    logic [WORD_W-1:0] push_data;
    logic              flush;
    logic              cyc_req, cyc_word;
    logic [1:0]        cyc_be;

    logic [1:0]    wr_n, rd_n, xfer_n;
    logic [CW-1:0] free;
    logic          load_stall, wr_stall, rd_stall;
    logic          load_ok, wr_ok, rd_ok, xfer;

    hdp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_n    (push_n),
        .push_data (push_data),
        .pop_n     (pop_n),
        .count     (fifo_count),
        .head      (fifo_head)
    );

    hdp_cyc_sel #(.DEPTH(DEPTH)) u_sel (
        .mode    (s_q.mode),
        .count   (fifo_count),
        .ptr_lsb (s_q.mem_ptr[0]),
        .req     (cyc_req),
        .word    (cyc_word),
        .be      (cyc_be)
    );

    always_comb begin
        wr_n   = host_wr_word ? 2'd2 : (host_wr_byte ? 2'd1 : 2'd0);
        rd_n   = host_rd_word ? 2'd2 : (host_rd_byte ? 2'd1 : 2'd0);
        xfer_n = cyc_word ? 2'd2 : 2'd1;
        free   = CW'(DEPTH) - fifo_count;

        load_stall = host_ptr_load && (s_q.mode == MODE_WR) && (fifo_count != '0);
        wr_stall   = !host_ptr_load && (s_q.mode == MODE_WR) && (wr_n != 2'd0)
                     && (free < CW'(wr_n));
        rd_stall   = !host_ptr_load && (s_q.mode == MODE_RD) && (rd_n != 2'd0)
                     && (fifo_count < CW'(rd_n));

        load_ok = host_ptr_load && !load_stall;
        wr_ok   = !host_ptr_load && (s_q.mode == MODE_WR) && (wr_n != 2'd0) && !wr_stall;
        rd_ok   = !host_ptr_load && (s_q.mode == MODE_RD) && (rd_n != 2'd0) && !rd_stall;
        xfer    = cyc_req && mem_gnt && !load_ok;

        flush = load_ok;
        if (s_q.mode == MODE_WR) begin
            push_n    = wr_ok ? wr_n : 2'd0;
            push_data = host_wdata;
            pop_n     = xfer ? xfer_n : 2'd0;
        end else begin
            push_n    = xfer ? xfer_n : 2'd0;
            push_data = cyc_word ? mem_rdata : {8'h00, mem_rdata[15:8]};
            pop_n     = rd_ok ? rd_n : 2'd0;
        end

        s_d = s_q;
        if (load_ok) begin
            s_d.mode     = host_ptr_rd ? MODE_RD : MODE_WR;
            s_d.mem_ptr  = host_ptr_val;
            s_d.host_ptr = host_ptr_val;
        end else begin
            if (xfer)
                s_d.mem_ptr = s_q.mem_ptr + ADDR_W'(xfer_n);
            if (wr_ok)
                s_d.host_ptr = s_q.host_ptr + ADDR_W'(wr_n);
            else if (rd_ok)
                s_d.host_ptr = s_q.host_ptr + ADDR_W'(rd_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_WR, mem_ptr: '0, host_ptr: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign host_stall = load_stall || wr_stall || rd_stall;
    assign host_rdata = host_rd_word ? fifo_head : {8'h00, fifo_head[7:0]};
    assign host_ptr   = s_q.host_ptr;
    assign mem_req    = cyc_req;
    assign mem_we     = (s_q.mode == MODE_WR);
    assign mem_addr   = s_q.mem_ptr;
    assign mem_be     = cyc_be;
    assign mem_wdata  = cyc_word ? fifo_head : {fifo_head[7:0], fifo_head[7:0]};
endmodule

// File: rtl/hdp_port_chk.sv
module hdp_port_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ptr_load,
    input logic              host_ptr_rd,
    input logic              host_wr_byte,
    input logic              host_wr_word,
    input logic              host_rd_byte,
    input logic              host_rd_word,
    input logic              host_stall,
    input logic [ADDR_W-1:0] host_ptr,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [1:0]        mem_be,
    input logic [CW-1:0]     fifo_count
);
    // R2: the queue never holds more than its depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    // R3: write-mode data always raises a request
    a_r3_req_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && fifo_count != '0) |-> mem_req);

    // R3: an ungranted request stays up
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt && !host_ptr_load) |=> mem_req);

    // R4: word cycles only at even addresses
    a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == 2'b11) |-> !mem_addr[0]);

    // R4: byte cycles use the lane picked by the address low bit
    a_r4_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be != 2'b11) |-> (mem_be == (mem_addr[0] ? 2'b10 : 2'b01)));

    // R6: an accepted byte read moves the host pointer by one
    a_r6_ptr_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_byte && !host_rd_word && !host_stall && !host_ptr_load && !mem_we)
        |=> host_ptr == $past(host_ptr) + ADDR_W'(1));

    // R7: an accepted read-mode load starts a prefetch next cycle
    a_r7_prefetch_start: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ptr_load && host_ptr_rd && !host_stall) |=> (mem_req && !mem_we));

    // R11: no strobe, no stall
    a_r11_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ptr_load || host_wr_byte || host_wr_word || host_rd_byte || host_rd_word)
        |-> !host_stall);
endmodule

bind hdp_port hdp_port_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_ptr_load (host_ptr_load),
    .host_ptr_rd   (host_ptr_rd),
    .host_wr_byte  (host_wr_byte),
    .host_wr_word  (host_wr_word),
    .host_rd_byte  (host_rd_byte),
    .host_rd_word  (host_rd_word),
    .host_stall    (host_stall),
    .host_ptr      (host_ptr),
    .mem_req       (mem_req),
    .mem_gnt       (mem_gnt),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_be        (mem_be),
    .fifo_count    (fifo_count)
);

// File: tb/hdp_port_tb.sv
module hdp_port_tb;
    localparam int unsigned ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_ptr_load = 1'b0;
    logic              host_ptr_rd = 1'b0;
    logic [ADDR_W-1:0] host_ptr_val = '0;
    logic              host_wr_byte = 1'b0;
    logic              host_wr_word = 1'b0;
    logic [15:0]       host_wdata = '0;
    logic              host_rd_byte = 1'b0;
    logic              host_rd_word = 1'b0;
    logic [15:0]       host_rdata;
    logic              host_stall;
    logic [ADDR_W-1:0] host_ptr;
    logic              mem_req;
    logic              mem_gnt = 1'b0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_be;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdp_port #(.ADDR_W(ADDR_W), .DEPTH(4)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_ptr_load (host_ptr_load),
        .host_ptr_rd   (host_ptr_rd),
        .host_ptr_val  (host_ptr_val),
        .host_wr_byte  (host_wr_byte),
        .host_wr_word  (host_wr_word),
        .host_wdata    (host_wdata),
        .host_rd_byte  (host_rd_byte),
        .host_rd_word  (host_rd_word),
        .host_rdata    (host_rdata),
        .host_stall    (host_stall),
        .host_ptr      (host_ptr),
        .mem_req       (mem_req),
        .mem_gnt       (mem_gnt),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_be        (mem_be),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata)
    );

    function automatic logic [15:0] init_val(int i);
        return {8'(i ^ 165), 8'(i * 7 + 3)};
    endfunction

    logic [15:0] mem [0:127];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
        end else if (mem_req && mem_gnt && mem_we) begin
            if (mem_be[0]) mem[mem_addr[7:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr[7:1]][15:8] <= mem_wdata[15:8];
        end
    end

    assign mem_rdata = mem[mem_addr[7:1]];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_ptr(logic [7:0] val, logic rd);
        @(negedge clk);
        host_ptr_load = 1'b1; host_ptr_rd = rd; host_ptr_val = val;
        @(posedge clk); #1;
        host_ptr_load = 1'b0;
    endtask

    task automatic hwrite(logic word, logic [15:0] data, logic exp_stall, string tag);
        @(negedge clk);
        host_wr_word = word; host_wr_byte = !word; host_wdata = data;
        #1 check({tag, " stall"}, 32'(host_stall), 32'(exp_stall));
        @(posedge clk); #1;
        host_wr_word = 1'b0; host_wr_byte = 1'b0;
    endtask

    task automatic hread(logic word, logic [15:0] exp_data, logic exp_stall, string tag);
        @(negedge clk);
        host_rd_word = word; host_rd_byte = !word;
        #1 check({tag, " stall"}, 32'(host_stall), 32'(exp_stall));
        if (!exp_stall) check({tag, " rdata"}, 32'(host_rdata), 32'(exp_data));
        @(posedge clk); #1;
        host_rd_word = 1'b0; host_rd_byte = 1'b0;
    endtask

    task automatic grant(int n);
        @(negedge clk);
        mem_gnt = 1'b1;
        repeat (n) @(posedge clk);
        #1 mem_gnt = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 req", 32'(mem_req), 0);
        check("R1 host_ptr", 32'(host_ptr), 0);
        check("R1 stall", 32'(host_stall), 0);
        check("R1 we", 32'(mem_we), 1);
    endtask

    task automatic t_write_even();
        load_ptr(8'h10, 1'b0);
        hwrite(1'b1, 16'h2211, 1'b0, "R2 w1");
        hwrite(1'b1, 16'h4433, 1'b0, "R2 w2");
        check("R6 host_ptr", 32'(host_ptr), 32'h14);
        check("R3 req", 32'(mem_req), 1);
        check("R3 we", 32'(mem_we), 1);
        check("R4 addr", 32'(mem_addr), 32'h10);
        check("R4 be", 32'(mem_be), 32'h3);
        check("R4 wdata", 32'(mem_wdata), 32'h2211);
        hwrite(1'b0, 16'h0055, 1'b1, "R2 full");
        check("R2 ptr after stall", 32'(host_ptr), 32'h14);
        check("R3 held", 32'(mem_req), 1);
        grant(1);
        check("R5 addr", 32'(mem_addr), 32'h12);
        check("R4 wdata2", 32'(mem_wdata), 32'h4433);
        grant(1);
        check("R3 req drop", 32'(mem_req), 0);
        check("R5 addr end", 32'(mem_addr), 32'h14);
        check("R4 mem8", 32'(mem[8]), 32'h2211);
        check("R4 mem9", 32'(mem[9]), 32'h4433);
        check("R2 mem10", 32'(mem[10]), 32'(init_val(10)));
    endtask

    task automatic t_write_odd();
        load_ptr(8'h21, 1'b0);
        hwrite(1'b1, 16'hBBAA, 1'b0, "R2 odd");
        check("R4 odd be", 32'(mem_be), 32'h2);
        check("R4 odd addr", 32'(mem_addr), 32'h21);
        check("R4 odd wdata", 32'(mem_wdata), 32'hAAAA);
        grant(1);
        check("R5 odd addr", 32'(mem_addr), 32'h22);
        check("R4 single be", 32'(mem_be), 32'h1);
        check("R4 single wdata", 32'(mem_wdata), 32'hBBBB);
        grant(1);
        check("R3 odd drop", 32'(mem_req), 0);
        check("R4 mem16", 32'(mem[16]), 32'({8'hAA, init_val(16)[7:0]}));
        check("R4 mem17", 32'(mem[17]), 32'({init_val(17)[15:8], 8'hBB}));
        check("R6 odd ptr", 32'(host_ptr), 32'h23);
    endtask

    task automatic t_load_wait();
        load_ptr(8'h30, 1'b0);
        hwrite(1'b0, 16'h0077, 1'b0, "R2 b");
        @(negedge clk);
        host_ptr_load = 1'b1; host_ptr_rd = 1'b1; host_ptr_val = 8'h40;
        #1 check("R10 stall", 32'(host_stall), 1);
        @(posedge clk); #1;
        check("R10 ptr kept", 32'(host_ptr), 32'h31);
        mem_gnt = 1'b1;
        @(posedge clk); #1;
        mem_gnt = 1'b0;
        check("R10 released", 32'(host_stall), 0);
        @(posedge clk); #1;
        host_ptr_load = 1'b0;
        check("R10 loaded", 32'(host_ptr), 32'h40);
        check("R7 req", 32'(mem_req), 1);
        check("R7 we", 32'(mem_we), 0);
        check("R7 addr", 32'(mem_addr), 32'h40);
        check("R7 be", 32'(mem_be), 32'h3);
        check("R10 drained", 32'(mem[24]), 32'({init_val(24)[15:8], 8'h77}));
    endtask

    task automatic t_prefetch();
        logic [15:0] w20, w21;
        w20 = init_val(32);
        w21 = init_val(33);
        grant(3);
        check("R8 full stop", 32'(mem_req), 0);
        check("R5 rd addr", 32'(mem_addr), 32'h44);
        hread(1'b1, w20, 1'b0, "R9 word");
        check("R6 rd ptr", 32'(host_ptr), 32'h42);
        check("R8 refill", 32'(mem_req), 1);
        hread(1'b0, {8'h00, w21[7:0]}, 1'b0, "R9 byte lo");
        hread(1'b1, 16'h0, 1'b1, "R9 short");
        hread(1'b0, {8'h00, w21[15:8]}, 1'b0, "R9 byte hi");
        hread(1'b0, 16'h0, 1'b1, "R9 empty");
        check("R6 rd ptr end", 32'(host_ptr), 32'h44);
    endtask

    task automatic t_odd_read();
        load_ptr(8'h51, 1'b1);
        check("R7 odd req", 32'(mem_req), 1);
        check("R7 odd be", 32'(mem_be), 32'h2);
        check("R7 odd addr", 32'(mem_addr), 32'h51);
        grant(1);
        check("R7 then word be", 32'(mem_be), 32'h3);
        check("R5 odd rd addr", 32'(mem_addr), 32'h52);
        grant(1);
        check("R8 three held", 32'(mem_req), 0);
        hread(1'b1, {init_val(41)[7:0], init_val(40)[15:8]}, 1'b0, "R9 odd word");
        check("R6 odd rd ptr", 32'(host_ptr), 32'h53);
    endtask

    task automatic t_flush();
        load_ptr(8'h60, 1'b1);
        grant(1);
        hread(1'b0, {8'h00, init_val(48)[7:0]}, 1'b0, "R7 flushed");
    endtask

    task automatic t_ignored();
        hwrite(1'b1, 16'h9999, 1'b0, "R11 wr in rd");
        check("R11 ptr rd mode", 32'(host_ptr), 32'h61);
        hread(1'b0, {8'h00, init_val(48)[15:8]}, 1'b0, "R11 data kept");
        load_ptr(8'h70, 1'b0);
        @(negedge clk);
        host_rd_word = 1'b1;
        #1 check("R11 rd in wr stall", 32'(host_stall), 0);
        @(posedge clk); #1;
        host_rd_word = 1'b0;
        check("R11 no req", 32'(mem_req), 0);
        check("R11 ptr wr mode", 32'(host_ptr), 32'h70);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_even();
        t_write_odd();
        t_load_wait();
        t_prefetch();
        t_odd_read();
        t_flush();
        t_ignored();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule